// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block is one programmable cell of a small FPGA-style fabric. A lookup mask, held as a configuration input, defines a Boolean function of the cell's data inputs. The cell also takes a carry input and a cascade input from its neighbour. It produces a cell output, a carry output and a cascade output, so that cells placed side by side form wide adders, counters and wide AND/OR functions. A 2-bit mode field chooses one of three uses. Normal mode is a full lookup table over every data input. Arithmetic mode splits the mask into a sum half and a carry half. Counter mode is arithmetic mode plus synchronous load and clear controls shared by a group of cells.

The cell holds one state flip-flop. It is clocked by one of two group clock lines. It can be cleared or preset asynchronously by either of two group control lines, and a chip-wide active-low reset always clears it. A configuration bit decides whether the cell output shows this register or the unregistered result. A second configuration bit decides whether the cascade input is combined with the lookup result by AND or by OR. A cell that does not use the cascade ties its cascade input to 1 for AND or to 0 for OR.

An n-bit adder chain uses n arithmetic cells plus one more cell at the end, whose only job is to bring the final carry out of the chain.

Top module: `logic_cell`

## Requirements
- R1: While `rstN` is low the register is 0 at once, with no clock edge needed, and this overrides every other control.
- R2: In normal mode (`cfgMode` = 0) the lookup result is `cfgMask[dataIn]`, with `dataIn[3]` as the most significant index bit. It is combined with `cascIn` by AND when `cfgCascOr` = 0 and by OR when `cfgCascOr` = 1. `cascOut` equals this combined result, and `carryOut` is 0.
- R3: In arithmetic mode (`cfgMode` = 1) the index is the 3-bit value {`carryIn`, `dataIn[1]`, `dataIn[0]`}. The lookup result is `cfgMask[index]`, combined with `cascIn` as in R2. `carryOut` is `cfgMask[8 + index]`. `dataIn[3:2]` do not change either output.
- R4: In counter mode (`cfgMode` = 2) the lookup works as in R3. On a rising edge of the selected clock the register takes one of three values, in this order of priority: 0 when `grpSyncClear` is high, otherwise `dataIn[2]` when `grpSyncLoad` is high, otherwise the combined result.
- R5: In normal and arithmetic modes, `grpSyncLoad` and `grpSyncClear` have no effect, and the register takes the combined result.
- R6: With `cfgRegOut` = 1, `leOut` shows the register. With `cfgRegOut` = 0, `leOut` shows the combined result at once, with no clock.
- R7: The register is clocked by the rising edge of `grpClkA` when `cfgClkSel` = 0 and of `grpClkB` when `cfgClkSel` = 1. Edges on the other line do not change it.
- R8: `cfgClrSrc` and `cfgPreSrc` each pick a source for an asynchronous control: 0 means none, 1 means `grpCtlA` and 2 means `grpCtlB`, each active high. The picked clear source forces the register to 0 and the picked preset source forces it to 1. Clear wins over preset, and both win over the clock and over the synchronous controls. A line that is not picked has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Chip-wide reset, active low, clears the register asynchronously |
| grpClkA | input | 1 | Group clock line A |
| grpClkB | input | 1 | Group clock line B |
| grpCtlA | input | 1 | Group control line A, usable as asynchronous clear or preset |
| grpCtlB | input | 1 | Group control line B, usable as asynchronous clear or preset |
| grpSyncLoad | input | 1 | Group synchronous load, counter mode only |
| grpSyncClear | input | 1 | Group synchronous clear, counter mode only |
| cfgMask | input | 2**LUT_INPUTS | Lookup mask; the upper half is the carry table in the 3-input modes |
| cfgMode | input | 2 | 0 normal, 1 arithmetic, 2 counter |
| cfgCascOr | input | 1 | Cascade combine: 0 AND, 1 OR |
| cfgRegOut | input | 1 | 1 shows the register on leOut, 0 shows the combined result |
| cfgClkSel | input | 1 | Register clock: 0 line A, 1 line B |
| cfgClrSrc | input | 2 | Asynchronous clear source: 0 none, 1 line A, 2 line B |
| cfgPreSrc | input | 2 | Asynchronous preset source: 0 none, 1 line A, 2 line B |
| dataIn | input | LUT_INPUTS | Data inputs |
| carryIn | input | 1 | Carry from the previous cell |
| cascIn | input | 1 | Cascade from the previous cell |
| leOut | output | 1 | Cell output |
| carryOut | output | 1 | Carry to the next cell |
| cascOut | output | 1 | Cascade to the next cell |

## Verification
The bench builds the cell with the default LUT_INPUTS = 4, so the mask is 16 bits. At this size every one of the 16 normal-mode indexes can be walked under each of the four cascade combinations. Every one of the 32 arithmetic input patterns can also be applied, with the two unused data inputs changing, and checked against the full-adder sum and majority carry. The small size also lets each clock line be watched edge by edge, so the bench can show that an edge on the line that is not selected leaves the register unchanged.

// File: rtl/logic_cell_pkg.sv
`timescale 1ns/1ps
package logic_cell_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_ARITH   = 2'd1,
    MODE_COUNTER = 2'd2,
    MODE_SPARE   = 2'd3
  } cellMode_t;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_CTL_A = 2'd1,
    SRC_CTL_B = 2'd2,
    SRC_SPARE = 2'd3
  } ctlSrc_t;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic asyncClr;
    logic asyncPre;
    logic syncClr;
    logic syncLd;
    logic useHalves;
  } cellStrobes_t;

endpackage

// File: rtl/cell_lut.sv
`timescale 1ns/1ps
// Binary 2:1 mux tree over a lookup mask, least significant select bit first.
module cell_lut #(
  parameter int SEL_W = 4,
  localparam int N = 1 << SEL_W
) (
  input  logic [N-1:0]     bits,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);

  for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
    localparam int W = 1 << (SEL_W - 1 - l);
    logic [W-1:0]   v;
    logic [2*W-1:0] src;
    if (l == 0) begin : g_first
      assign src = bits;
    end else begin : g_next
      assign src = g_lvl[l-1].v;
    end
    for (genvar j = 0; j < W; j++) begin : g_pair
      assign v[j] = sel[l] ? src[2*j+1] : src[2*j];
    end
  end

  assign y = g_lvl[SEL_W-1].v[0];

endmodule

// File: rtl/cell_ctrl.sv
`timescale 1ns/1ps
module cell_ctrl
  import logic_cell_pkg::*;
(
  input  logic         rstN,
  input  logic         grpClkA,
  input  logic         grpClkB,
  input  logic         grpCtlA,
  input  logic         grpCtlB,
  input  logic         grpSyncLoad,
  input  logic         grpSyncClear,
  input  logic [1:0]   cfgMode,
  input  logic         cfgClkSel,
  input  logic [1:0]   cfgClrSrc,
  input  logic [1:0]   cfgPreSrc,
  output logic         regClk,
  output cellStrobes_t strb
);

  cellMode_t mode;
  logic      isCounter;

  function automatic logic srcHit(input logic [1:0] src, input logic a, input logic b);
    case (ctlSrc_t'(src))
      SRC_CTL_A: srcHit = a;
      SRC_CTL_B: srcHit = b;
      default:   srcHit = 1'b0;
    endcase
  endfunction

  assign mode      = cellMode_t'(cfgMode);
  assign isCounter = (mode == MODE_COUNTER);
  assign regClk    = cfgClkSel ? grpClkB : grpClkA;

  always_comb begin
    strb.asyncClr  = !rstN || srcHit(cfgClrSrc, grpCtlA, grpCtlB);
    strb.asyncPre  = srcHit(cfgPreSrc, grpCtlA, grpCtlB);
    strb.syncClr   = isCounter && grpSyncClear;
    strb.syncLd    = isCounter && grpSyncLoad;
    strb.useHalves = isCounter || (mode == MODE_ARITH);
  end

endmodule

// File: rtl/cell_datapath.sv
`timescale 1ns/1ps
module cell_datapath
  import logic_cell_pkg::*;
#(
  parameter int LUT_INPUTS = 4,
  localparam int LUT_BITS  = 1 << LUT_INPUTS,
  localparam int HALF_SEL  = LUT_INPUTS - 1,
  localparam int HALF_BITS = 1 << HALF_SEL
) (
  input  logic [LUT_BITS-1:0]   cfgMask,
  input  logic                  cfgCascOr,
  input  logic                  cfgRegOut,
  input  logic [LUT_INPUTS-1:0] dataIn,
  input  logic                  carryIn,
  input  logic                  cascIn,
  input  logic                  regClk,
  input  cellStrobes_t          strb,
  output logic                  leOut,
  output logic                  carryOut,
  output logic                  cascOut,
  output logic                  regQ
);

  logic [HALF_SEL-1:0] halfSel;
  logic fullBit, sumBit, carryBit, lutBit, combBit, loadBit, nextD;
  logic aClr, aPre;

  assign halfSel = {carryIn, dataIn[HALF_SEL-2:0]};
  assign loadBit = dataIn[HALF_SEL-1];

  cell_lut #(.SEL_W(LUT_INPUTS)) uFull (
    .bits(cfgMask), .sel(dataIn), .y(fullBit)
  );
  cell_lut #(.SEL_W(HALF_SEL)) uSum (
    .bits(cfgMask[HALF_BITS-1:0]), .sel(halfSel), .y(sumBit)
  );
  cell_lut #(.SEL_W(HALF_SEL)) uCarry (
    .bits(cfgMask[LUT_BITS-1:HALF_BITS]), .sel(halfSel), .y(carryBit)
  );

  always_comb begin
    lutBit   = strb.useHalves ? sumBit : fullBit;
    combBit  = cfgCascOr ? (lutBit | cascIn) : (lutBit & cascIn);
    carryOut = strb.useHalves & carryBit;
    if (strb.syncClr)     nextD = 1'b0;
    else if (strb.syncLd) nextD = loadBit;
    else                  nextD = combBit;
  end

  assign aClr = strb.asyncClr;
  assign aPre = strb.asyncPre;

  always_ff @(posedge regClk or posedge aClr or posedge aPre) begin
    if (aClr)      regQ <= 1'b0;
    else if (aPre) regQ <= 1'b1;
    else           regQ <= nextD;
  end

  assign cascOut = combBit;
  assign leOut   = cfgRegOut ? regQ : combBit;

endmodule

// File: rtl/logic_cell.sv
`timescale 1ns/1ps
module logic_cell
  import logic_cell_pkg::*;
#(
  parameter int LUT_INPUTS = 4,
  localparam int LUT_BITS  = 1 << LUT_INPUTS
) (
  input  logic                  rstN,
  input  logic                  grpClkA,
  input  logic                  grpClkB,
  input  logic                  grpCtlA,
  input  logic                  grpCtlB,
  input  logic                  grpSyncLoad,
  input  logic                  grpSyncClear,
  input  logic [LUT_BITS-1:0]   cfgMask,
  input  logic [1:0]            cfgMode,
  input  logic                  cfgCascOr,
  input  logic                  cfgRegOut,
  input  logic                  cfgClkSel,
  input  logic [1:0]            cfgClrSrc,
  input  logic [1:0]            cfgPreSrc,
  input  logic [LUT_INPUTS-1:0] dataIn,
  input  logic                  carryIn,
  input  logic                  cascIn,
  output logic                  leOut,
  output logic                  carryOut,
  output logic                  cascOut
);

  cellStrobes_t strb;
  logic         regClk;
  logic         regQ;

  cell_ctrl uCtrl (
    .rstN(rstN), .grpClkA(grpClkA), .grpClkB(grpClkB),
    .grpCtlA(grpCtlA), .grpCtlB(grpCtlB),
    .grpSyncLoad(grpSyncLoad), .grpSyncClear(grpSyncClear),
    .cfgMode(cfgMode), .cfgClkSel(cfgClkSel),
    .cfgClrSrc(cfgClrSrc), .cfgPreSrc(cfgPreSrc),
    .regClk(regClk), .strb(strb)
  );

  cell_datapath #(.LUT_INPUTS(LUT_INPUTS)) uPath (
    .cfgMask(cfgMask), .cfgCascOr(cfgCascOr), .cfgRegOut(cfgRegOut),
    .dataIn(dataIn), .carryIn(carryIn), .cascIn(cascIn),
    .regClk(regClk), .strb(strb),
    .leOut(leOut), .carryOut(carryOut), .cascOut(cascOut), .regQ(regQ)
  );

endmodule

// File: rtl/logic_cell_chk.sv
`timescale 1ns/1ps
module logic_cell_chk (
  input logic       rstN,
  input logic       grpClkA,
  input logic       grpCtlA,
  input logic       grpCtlB,
  input logic       grpSyncLoad,
  input logic       grpSyncClear,
  input logic [1:0] cfgMode,
  input logic       cfgCascOr,
  input logic       cfgClkSel,
  input logic [1:0] cfgClrSrc,
  input logic [1:0] cfgPreSrc,
  input logic       loadData,
  input logic       cascIn,
  input logic       cascOut,
  input logic       carryOut,
  input logic       regQ
);

  logic clrActive, preActive, syncQuiet;

  assign clrActive = (cfgClrSrc == 2'd1 && grpCtlA) || (cfgClrSrc == 2'd2 && grpCtlB);
  assign preActive = (cfgPreSrc == 2'd1 && grpCtlA) || (cfgPreSrc == 2'd2 && grpCtlB);
  assign syncQuiet = (cfgMode == 2'd2) && !cfgClkSel && !clrActive && !preActive;

  always @(posedge grpClkA) begin
    if (!rstN) begin
      assert_chip_clear_R1: assert (regQ == 1'b0)
        else $error("chip reset did not clear register");
    end
  end

  assert_and_absorb_R2: assert property (@(posedge grpClkA) disable iff (!rstN)
    (cfgMode == 2'd0 && !cfgCascOr && !cascIn) |-> !cascOut);

  assert_or_pass_R2: assert property (@(posedge grpClkA) disable iff (!rstN)
    (cfgCascOr && cascIn) |-> cascOut);

  assert_no_carry_normal_R2: assert property (@(posedge grpClkA) disable iff (!rstN)
    (cfgMode == 2'd0) |-> !carryOut);

  assert_sync_clear_R4: assert property (@(posedge grpClkA) disable iff (!rstN)
    (syncQuiet && grpSyncClear) |=> (regQ == 1'b0 || preActive || clrActive));

  assert_sync_load_R4: assert property (@(posedge grpClkA) disable iff (!rstN)
    (syncQuiet && !grpSyncClear && grpSyncLoad)
      |=> (regQ == $past(loadData) || preActive || clrActive));

  assert_async_clear_R8: assert property (@(posedge grpClkA) disable iff (!rstN)
    clrActive |-> (regQ == 1'b0));

  assert_async_preset_R8: assert property (@(posedge grpClkA) disable iff (!rstN)
    (preActive && !clrActive) |-> (regQ == 1'b1));

endmodule

bind logic_cell logic_cell_chk uChk (
  .rstN(rstN), .grpClkA(grpClkA), .grpCtlA(grpCtlA), .grpCtlB(grpCtlB),
  .grpSyncLoad(grpSyncLoad), .grpSyncClear(grpSyncClear),
  .cfgMode(cfgMode), .cfgCascOr(cfgCascOr), .cfgClkSel(cfgClkSel),
  .cfgClrSrc(cfgClrSrc), .cfgPreSrc(cfgPreSrc),
  .loadData(dataIn[LUT_INPUTS-2]), .cascIn(cascIn),
  .cascOut(cascOut), .carryOut(carryOut), .regQ(regQ)
);

// File: tb/sim_logic_cell.sv
`timescale 1ns/1ps
module sim_logic_cell;

  logic        clk = 1'b0;
  logic        grpClkB = 1'b0;
  logic        rstN = 1'b0;
  logic        grpCtlA = 1'b0, grpCtlB = 1'b0;
  logic        grpSyncLoad = 1'b0, grpSyncClear = 1'b0;
  logic [15:0] cfgMask = 16'h0000;
  logic [1:0]  cfgMode = 2'd0;
  logic        cfgCascOr = 1'b0, cfgRegOut = 1'b1, cfgClkSel = 1'b0;
  logic [1:0]  cfgClrSrc = 2'd0, cfgPreSrc = 2'd0;
  logic [3:0]  dataIn = 4'h0;
  logic        carryIn = 1'b0, cascIn = 1'b1;
  logic        leOut, carryOut, cascOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) grpClkB <= ~grpClkB;

  logic_cell u0 (
    .rstN(rstN), .grpClkA(clk), .grpClkB(grpClkB),
    .grpCtlA(grpCtlA), .grpCtlB(grpCtlB),
    .grpSyncLoad(grpSyncLoad), .grpSyncClear(grpSyncClear),
    .cfgMask(cfgMask), .cfgMode(cfgMode), .cfgCascOr(cfgCascOr),
    .cfgRegOut(cfgRegOut), .cfgClkSel(cfgClkSel),
    .cfgClrSrc(cfgClrSrc), .cfgPreSrc(cfgPreSrc),
    .dataIn(dataIn), .carryIn(carryIn), .cascIn(cascIn),
    .leOut(leOut), .carryOut(carryOut), .cascOut(cascOut)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic idle();
    grpCtlA = 0; grpCtlB = 0; grpSyncLoad = 0; grpSyncClear = 0;
    cfgMask = 16'h0000; cfgMode = 2'd0; cfgCascOr = 0; cfgRegOut = 1;
    cfgClkSel = 0; cfgClrSrc = 2'd0; cfgPreSrc = 2'd0;
    dataIn = 4'h0; carryIn = 0; cascIn = 1;
  endtask

  // Applies stimulus at a falling edge, checks the register one cycle later.
  task automatic step(input string tag, input logic sclr, input logic sld,
                      input logic d3, input logic a, input logic b, input logic c,
                      input logic exp);
    @(negedge clk);
    grpSyncClear = sclr; grpSyncLoad = sld;
    dataIn = {1'b0, d3, b, a}; carryIn = c;
    @(negedge clk);
    chk(tag, leOut, exp);
  endtask

  task automatic pulseClear();
    cfgClrSrc = 2'd1; grpCtlA = 1; #1; grpCtlA = 0; cfgClrSrc = 2'd0; #1;
  endtask

  task automatic t_reset();
    idle();
    repeat (2) @(negedge clk);
    chk("R1 held in reset", leOut, 1'b0);
    rstN = 1;
    cfgMask = 16'hFFFF;
    @(negedge clk);
    chk("R1 register loads after release", leOut, 1'b1);
    #1 rstN = 0;
    #1 chk("R1 async clear mid-cycle", leOut, 1'b0);
    @(negedge clk);
    chk("R1 stays clear across edge", leOut, 1'b0);
    rstN = 1;
  endtask

  task automatic t_normal();
    idle();
    cfgRegOut = 0; cfgMask = 16'hA5C3;
    for (int i = 0; i < 16; i++) begin
      dataIn = 4'(i);
      cfgCascOr = 0; cascIn = 1; #1;
      chk("R2 and-pass leOut", leOut, cfgMask[i]);
      chk("R2 cascOut", cascOut, cfgMask[i]);
      chk("R2 carryOut zero", carryOut, 1'b0);
      cascIn = 0; #1;
      chk("R2 and-absorb", cascOut, 1'b0);
      cfgCascOr = 1; #1;
      chk("R2 or-pass", leOut, cfgMask[i]);
      cascIn = 1; #1;
      chk("R2 or-absorb", cascOut, 1'b1);
    end
  endtask

  task automatic t_arith();
    idle();
    cfgRegOut = 0; cfgMode = 2'd1; cfgMask = 16'hE896;
    for (int k = 0; k < 32; k++) begin
      logic [4:0] kv;
      kv = 5'(k);
      dataIn = {kv[4:3], kv[1:0]}; carryIn = kv[2]; #1;
      chk("R3 sum", leOut, ^kv[2:0]);
      chk("R3 carry", carryOut, (kv[0] & kv[1]) | (kv[0] & kv[2]) | (kv[1] & kv[2]));
    end
  endtask

  task automatic t_counter();
    idle();
    cfgMode = 2'd2; cfgMask = 16'hE896;
    step("R4 clear over load", 1, 1, 1, 1, 0, 0, 1'b0);
    step("R4 load data3", 0, 1, 1, 0, 0, 0, 1'b1);
    step("R4 load zero", 0, 1, 0, 1, 0, 0, 1'b0);
    step("R4 follows sum one", 0, 0, 0, 1, 0, 0, 1'b1);
    step("R4 follows sum zero", 0, 0, 1, 1, 1, 0, 1'b0);
    idle();
  endtask

  task automatic t_ignored();
    idle();
    cfgMask = 16'hFFFF;
    step("R5 normal ignores clear", 1, 0, 0, 0, 0, 0, 1'b1);
    cfgMode = 2'd1; cfgMask = 16'hE896;
    step("R5 arith ignores load", 0, 1, 0, 1, 0, 0, 1'b1);
    step("R5 arith ignores clear", 1, 1, 0, 1, 0, 0, 1'b1);
    idle();
  endtask

  task automatic t_outsel();
    idle();
    cfgMask = 16'hFFFF; cfgRegOut = 0;
    @(negedge clk);
    pulseClear();
    chk("R6 comb output", leOut, 1'b1);
    cfgRegOut = 1; #1;
    chk("R6 register output before edge", leOut, 1'b0);
    @(negedge clk);
    chk("R6 register output after edge", leOut, 1'b1);
  endtask

  task automatic t_clksel();
    idle();
    cfgMask = 16'hFFFF; cfgClkSel = 1;
    @(posedge grpClkB);
    @(negedge clk);
    pulseClear();
    @(negedge clk);
    chk("R7 no capture on line A edge", leOut, 1'b0);
    @(negedge clk);
    chk("R7 capture on line B edge", leOut, 1'b1);
    idle();
  endtask

  task automatic t_async();
    idle();
    @(negedge clk);
    cfgPreSrc = 2'd1; grpCtlA = 1; #1;
    chk("R8 preset async", leOut, 1'b1);
    @(negedge clk);
    chk("R8 preset holds over clock", leOut, 1'b1);
    cfgClrSrc = 2'd2; grpCtlB = 1; #1;
    chk("R8 clear beats preset", leOut, 1'b0);
    @(negedge clk);
    grpCtlA = 0; grpCtlB = 0; cfgPreSrc = 2'd0; cfgClrSrc = 2'd0;
    cfgMask = 16'hFFFF; grpCtlA = 1; grpCtlB = 1;
    @(negedge clk);
    chk("R8 unselected lines ignored high", leOut, 1'b1);
    cfgMask = 16'h0000;
    @(negedge clk);
    chk("R8 unselected lines ignored low", leOut, 1'b0);
    grpCtlB = 0; cfgPreSrc = 2'd1; #1;
    chk("R8 preset via line A", leOut, 1'b1);
    cfgMode = 2'd2; grpSyncClear = 1;
    @(negedge clk);
    chk("R8 async beats sync clear", leOut, 1'b1);
    idle();
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_arith();
    t_counter();
    t_ignored();
    t_outsel();
    t_clksel();
    t_async();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule